// File: doc/BRIEF.md
# Multi-Pin Input Event Interrupt Detector

This block watches a group of general-purpose input pins and turns selected events on them into one interrupt request for a processor. Each pin is brought into the peripheral clock domain through a synchronizer. The pin's own 3-bit trigger code then decides what counts as an event. The choices are a rising edge, a falling edge, either edge, a low level or a high level.

Every event sets a sticky pending bit for its pin. The bit stays set until software writes a one to that pin's clear strobe. Edge triggers produce one event per transition. Level triggers produce an event in every cycle the pin holds the chosen level, so a pending bit that is cleared while the level persists sets again at once. A per-pin enable masks the pending bit from the request line without erasing it. The request is the registered OR of all unmasked pending bits.

Top module: `gpio_evt_irq`

## Requirements
- R1: While reset is asserted, and on leaving it, `status_o` is all zeros and `irq_o` is 0.
- R2: Trigger code 1 (rising) sets the pin's status bit when the synchronized sample goes from 0 to 1. The bit becomes visible on the third rising clock edge after the pin changes. A falling transition does not set it.
- R3: Trigger code 2 (falling) sets the status bit when the synchronized sample goes from 1 to 0, with the same three-edge latency. A rising transition does not set it.
- R4: Trigger code 3 (any edge) sets the status bit on every change of the synchronized sample, in either direction.
- R5: Trigger code 4 (low level) produces an event in every cycle the synchronized sample is 0. Trigger code 5 (high level) produces an event in every cycle it is 1. A change of code that selects an already-present level sets the bit on the next edge.
- R6: Trigger codes 0, 6 and 7 never set the status bit, whatever the pin does.
- R7: A status bit stays set until a clock edge samples a 1 on its `clr_i` bit. Clear bits of other pins have no effect on it. Any number of further events before the clear merge into the one pending bit, and a single clear with no new event empties it.
- R8: When a clear and a new event for the same pin meet at one edge, the bit stays set. A level trigger whose level is still present therefore keeps its bit set across a clear.
- R9: `irq_o` is the OR over all pins of status AND `en_i`, registered, so it follows one edge after the status it reflects. Dropping a pin's enable removes that pin from `irq_o` without clearing its status bit.
- R10: After reset, the first synchronized samples are not compared against reset values. A pin already high when reset is released raises no edge event.
- R11: Pin i takes its trigger code from `trig_i[3*i+2:3*i]`, and `en_i[i]`, `clr_i[i]` and `status_o[i]` belong to pin i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | NUM_PINS | Asynchronous input pins |
| en_i | input | NUM_PINS | Per-pin mask for the interrupt request |
| trig_i | input | 3*NUM_PINS | Per-pin trigger code, 3 bits each |
| clr_i | input | NUM_PINS | Write-one-to-clear strobes for the status bits |
| status_o | output | NUM_PINS | Sticky pending bits |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A pin change reaches the status output on the third rising edge after it is driven. The request line follows one edge later, on the fourth. A clear, an enable change or a trigger-code change acts on the very next edge. The bench drives every input just after a falling edge and samples just after the falling edge that follows the due rising edge. For each pin transition it checks that the bit is still clear one edge before it is due and set exactly when it is due. The same-edge clear-and-set case is timed so that the clear strobe lands on the one edge where the event is present.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  localparam int TRIG_W = 3;

  typedef enum logic [TRIG_W-1:0] {
    TRIG_OFF  = 3'd0,
    TRIG_RISE = 3'd1,
    TRIG_FALL = 3'd2,
    TRIG_ANY  = 3'd3,
    TRIG_LOW  = 3'd4,
    TRIG_HIGH = 3'd5
  } trig_e;
endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
  parameter int NUM_PINS = 8,
  parameter int STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] d_i,
  output logic [NUM_PINS-1:0] q_o,
  output logic                armed_o
);
  // the pipeline fills after STAGES edges, and the previous-sample register one edge later
  localparam int ARM_CNT = STAGES + 1;
  localparam int CNT_W   = $clog2(ARM_CNT + 1);

  logic [NUM_PINS-1:0] stg_q [STAGES];
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic                cnt_en;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [NUM_PINS-1:0] stg_d;
      if (s == 0) begin : g_first
        assign stg_d = d_i;
      end else begin : g_next
        assign stg_d = stg_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_d;
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];

  always_comb begin
    cnt_en = (cnt_q != CNT_W'(ARM_CNT));
    cnt_d  = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign armed_o = !cnt_en;

  // R10: once armed, the block stays armed until the next reset
  assert_armed_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    armed_o |=> armed_o);
endmodule

// File: rtl/gpio_evt_trig.sv
module gpio_evt_trig
  import gpio_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              armed_i,
  input  logic              cur_i,
  input  logic [TRIG_W-1:0] trig_i,
  output logic              evt_o
);
  logic prev_q;
  logic rise, fall, hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cur_i;
  end

  always_comb begin
    rise = cur_i & ~prev_q;
    fall = ~cur_i & prev_q;
    case (trig_i)
      TRIG_RISE: hit = rise;
      TRIG_FALL: hit = fall;
      TRIG_ANY:  hit = rise | fall;
      TRIG_LOW:  hit = ~cur_i;
      TRIG_HIGH: hit = cur_i;
      default:   hit = 1'b0;
    endcase
    evt_o = armed_i & hit;
  end

  assert_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o && trig_i == TRIG_RISE) |-> (cur_i && !$past(cur_i)));
  assert_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o && trig_i == TRIG_FALL) |-> (!cur_i && $past(cur_i)));
  assert_any_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o && trig_i == TRIG_ANY) |-> (cur_i != $past(cur_i)));
  assert_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_i && trig_i == TRIG_HIGH && cur_i) |-> evt_o);
  assert_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i == TRIG_OFF || trig_i > TRIG_HIGH) |-> !evt_o);
endmodule

// File: rtl/gpio_evt_status.sv
module gpio_evt_status #(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] evt_i,
  input  logic [NUM_PINS-1:0] clr_i,
  output logic [NUM_PINS-1:0] status_o
);
  logic [NUM_PINS-1:0] status_q, status_d;
  logic                upd;

  always_comb begin
    // a set in the same cycle as a clear wins
    status_d = (status_q & ~clr_i) | evt_i;
    upd      = (|evt_i) | (|(clr_i & status_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   status_q <= '0;
    else if (upd) status_q <= status_d;
  end

  assign status_o = status_q;

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status_q & ~clr_i)) |=> ((status_q & $past(status_q & ~clr_i)) == $past(status_q & ~clr_i)));
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~evt_i)) |=> ((status_q & $past(clr_i & ~evt_i)) == '0));
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((status_q & $past(evt_i)) == $past(evt_i)));
endmodule

// File: rtl/gpio_evt_irq.sv
module gpio_evt_irq
  import gpio_evt_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PINS-1:0]        pin_i,
  input  logic [NUM_PINS-1:0]        en_i,
  input  logic [NUM_PINS*TRIG_W-1:0] trig_i,
  input  logic [NUM_PINS-1:0]        clr_i,
  output logic [NUM_PINS-1:0]        status_o,
  output logic                       irq_o
);
  logic [1:0]          rst_pipe_q;
  logic                rst_core_n;
  logic [NUM_PINS-1:0] pin_sync;
  logic                armed;
  logic [NUM_PINS-1:0] evt;
  logic                irq_q, irq_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  gpio_evt_sync #(
    .NUM_PINS (NUM_PINS),
    .STAGES   (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .d_i     (pin_i),
    .q_o     (pin_sync),
    .armed_o (armed)
  );

  genvar p;
  generate
    for (p = 0; p < NUM_PINS; p++) begin : g_pin
      gpio_evt_trig u_trig (
        .clk     (clk),
        .rst_n   (rst_core_n),
        .armed_i (armed),
        .cur_i   (pin_sync[p]),
        .trig_i  (trig_i[p*TRIG_W +: TRIG_W]),
        .evt_o   (evt[p])
      );
    end
  endgenerate

  gpio_evt_status #(
    .NUM_PINS (NUM_PINS)
  ) u_status (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .evt_i    (evt),
    .clr_i    (clr_i),
    .status_o (status_o)
  );

  assign irq_d = |(status_o & en_i);

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) irq_q <= 1'b0;
    else             irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((status_o & en_i) == '0) |=> !irq_o);
  assert_irq_raised_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (|(status_o & en_i)) |=> irq_o);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_core_n |-> (status_o == '0 && !irq_o));
  assert_no_early_evt_R10: assert property (@(posedge clk) disable iff (!rst_core_n)
    !armed |-> (evt == '0));
endmodule

// File: tb/tb_gpio_evt_irq.sv
`timescale 1ns/1ps
module tb_gpio_evt_irq;
  localparam int NP = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NP-1:0]   pin, en, clr;
  logic [NP*3-1:0] trig;
  logic [NP-1:0]   status;
  logic            irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  gpio_evt_irq #(.NUM_PINS(NP), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .en_i(en), .trig_i(trig),
    .clr_i(clr), .status_o(status), .irq_o(irq)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_trig(int p, logic [2:0] code);
    trig[3*p +: 3] = code;
  endtask

  task automatic pulse_clr(logic [NP-1:0] m);
    clr = m;
    tick(1);
    clr = '0;
  endtask

  // R1, R10: quiet reset and no false edge with pins already high
  task automatic t_reset();
    rst_n = 1'b0; pin = 8'b0000_0011; en = '1; clr = '0; trig = '0;
    set_trig(0, 3'd1);
    set_trig(1, 3'd3);
    tick(3);
    check("R1 status in reset", status, 0);
    check("R1 irq in reset", irq, 0);
    rst_n = 1'b1;
    tick(10);
    check("R10 no false edge after reset", status, 0);
    check("R1 irq after reset", irq, 0);
    en = '0;
  endtask

  // R2, R7, R11: rising edge on pin 2
  task automatic t_rise();
    set_trig(2, 3'd1);
    pin[2] = 1'b1;
    tick(2);
    check("R2 rise not yet due", status[2], 0);
    tick(1);
    check("R2 rise seen on third edge", status, 8'h04);
    pulse_clr(8'h08);
    check("R7 other clear bit ignored", status[2], 1);
    tick(5);
    check("R7 status sticky", status[2], 1);
    pulse_clr(8'h04);
    check("R7 clear empties bit", status[2], 0);
    pin[2] = 1'b0;
    tick(5);
    check("R2 falling ignored in rise mode", status[2], 0);
  endtask

  // R3: falling edge on pin 3
  task automatic t_fall();
    set_trig(3, 3'd2);
    pin[3] = 1'b1;
    tick(5);
    check("R3 rising ignored in fall mode", status[3], 0);
    pin[3] = 1'b0;
    tick(2);
    check("R3 fall not yet due", status[3], 0);
    tick(1);
    check("R3 fall seen on third edge", status[3], 1);
    pulse_clr(8'h08);
    check("R3 cleared", status[3], 0);
  endtask

  // R4, R7, R8: any edge on pin 4, back-to-back edges, clear meets set
  task automatic t_any();
    set_trig(4, 3'd3);
    pin[4] = 1'b1;
    tick(3);
    check("R4 rise in any mode", status[4], 1);
    pulse_clr(8'h10);
    pin[4] = 1'b0;
    tick(3);
    check("R4 fall in any mode", status[4], 1);
    for (int k = 0; k < 5; k++) begin
      pin[4] = ~pin[4];
      tick(1);
    end
    tick(3);
    check("R7 burst merged", status[4], 1);
    pulse_clr(8'h10);
    check("R7 one clear empties burst", status[4], 0);
    pin[4] = ~pin[4];
    tick(3);
    check("R4 set before clash", status[4], 1);
    pin[4] = ~pin[4];
    tick(2);
    pulse_clr(8'h10);
    check("R8 set wins over clear", status[4], 1);
    pulse_clr(8'h10);
    check("R8 plain clear after clash", status[4], 0);
  endtask

  // R5, R8: level modes on pins 5 and 6
  task automatic t_level();
    set_trig(5, 3'd5);
    pin[5] = 1'b1;
    tick(3);
    check("R5 high level sets", status[5], 1);
    pulse_clr(8'h20);
    check("R8 held level survives clear", status[5], 1);
    pin[5] = 1'b0;
    tick(3);
    pulse_clr(8'h20);
    check("R5 clear after level gone", status[5], 0);
    set_trig(6, 3'd4);
    tick(1);
    check("R5 low level sets next edge", status[6], 1);
    pin[6] = 1'b1;
    tick(3);
    pulse_clr(8'h40);
    check("R5 low level stops when high", status[6], 0);
  endtask

  // R6: disabled codes on pin 7
  task automatic t_disabled();
    logic [2:0] codes [3] = '{3'd0, 3'd6, 3'd7};
    for (int c = 0; c < 3; c++) begin
      set_trig(7, codes[c]);
      pin[7] = 1'b1;
      tick(4);
      pin[7] = 1'b0;
      tick(4);
      check("R6 disabled code sets nothing", status[7], 0);
    end
  endtask

  // R9: interrupt request and masking on pin 2
  task automatic t_irq();
    en = 8'h04;
    pin[2] = 1'b1;
    tick(3);
    check("R9 status before irq", status[2], 1);
    check("R9 irq one edge later", irq, 0);
    tick(1);
    check("R9 irq raised", irq, 1);
    en = '0;
    tick(1);
    check("R9 mask drops irq", irq, 0);
    check("R9 mask keeps status", status[2], 1);
    en = 8'h04;
    tick(1);
    check("R9 unmask restores irq", irq, 1);
    pulse_clr(8'h04);
    check("R9 irq lags clear", irq, 1);
    tick(1);
    check("R9 irq drops after clear", irq, 0);
  endtask

  initial begin
    t_reset();
    t_rise();
    t_fall();
    t_any();
    t_level();
    t_disabled();
    t_irq();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule